// File: doc/BRIEF.md
# Radix-2 SRT Divider with Selectable Comparison Constant

This block divides an unsigned fraction by a normalized fraction, one quotient digit per clock, using radix-2 SRT digit selection. Each step doubles the partial remainder and looks at its few leading bits only. It then picks a digit of +1, 0 or -1 and subtracts the divisor, adds it, or does nothing further. The constant for that comparison is either a fixed one half or is taken from the two leading fraction bits of the divisor. A mode input chooses between the two at each start.

The digits are collected as two bit vectors: one for positive digits and one for negative digits. A single finishing step turns them into a binary quotient and, when needed, corrects a negative remainder. The block also counts the add and subtract steps that a division took. Running the same operands in both modes shows how many arithmetic steps the adaptive constant saves or costs.

Top module: `srt_divider`

## Requirements
- R1: While reset is asserted and after its release, `done`, `quotient`, `remainder` and `op_count` are all zero.
- R2: A `start` sampled high while idle begins a division. `done` is then high for exactly one cycle, the cycle after the (W+1)-th rising edge that follows the edge which sampled `start`. That is W iteration edges plus one finishing edge.
- R3: For a divisor D with bit W-1 set and a dividend X < D, both read as W-bit integers, the block reports `quotient` = floor(X·2^W / D) and `remainder` = X·2^W mod D, with 0 ≤ `remainder` < D. This holds in both modes.
- R4: With `adaptive` low, the constant K is one half. When the doubled remainder 2r ≥ K the step takes digit +1 and subtracts D. When 2r < -K it takes digit -1 and adds D. Otherwise it takes digit 0 and does a shift only.
- R5: With `adaptive` high, K equals binary 0.ab, where a and b are divisor bits W-1 and W-2, so K is 1/2 or 3/4. The selection rule of R4 applies unchanged.
- R6: `op_count` equals the number of nonzero digits taken in the W iterations. The final add-back that corrects a negative remainder is not counted. A zero dividend gives a count of 0.
- R7: Operands and mode are captured at the edge that samples `start`. A `start` pulse, or any change of the operands or the mode, while a division is in progress has no effect on its results or its timing.
- R8: `quotient`, `remainder` and `op_count` hold their values from one `done` until the next finishing edge, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| adaptive | input | 1 | 1: constant from divisor bits; 0: fixed one half |
| dividend | input | W | Dividend fraction, must be below the divisor |
| divisor | input | W | Divisor fraction, bit W-1 must be 1 |
| quotient | output | W | Binary quotient fraction |
| remainder | output | W | Final non-negative remainder, scaled by 2^W |
| op_count | output | $clog2(W+1) | Add/subtract steps used by the last division |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random normalized divisors with dividends below them are run in both modes. The quotient and remainder are compared against plain integer division, and the operation count against a step model written as inequalities on the doubled remainder. The mode-dependent count separates the two comparison constants, because a wrong constant still gives a correct quotient but a different count. Directed cases cover a zero dividend, a dividend one below the divisor, and the smallest and largest divisors, where the remainder runs close to its bounds. Further runs inject a start and changed operands mid-division, and change the inputs after completion, to show that neither disturbs the results.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;

  typedef enum logic [1:0] {
    DIG_ZERO  = 2'b00,
    DIG_PLUS  = 2'b01,
    DIG_MINUS = 2'b10
  } digit_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } state_e;

  // comparison constant in quarter units
  function automatic logic [4:0] quarter_const(input logic adaptive, input logic [1:0] lead);
    return adaptive ? {3'b000, lead} : 5'd2;
  endfunction

  // digit from the truncated estimate (quarter units) and the constant
  function automatic digit_e pick_digit(input logic signed [4:0] est, input logic [4:0] kq);
    logic signed [5:0] k;
    logic signed [5:0] e;
    k = $signed({1'b0, kq});
    e = {est[4], est};
    if (e >= k)
      return DIG_PLUS;
    else if (e < -k)
      return DIG_MINUS;
    else
      return DIG_ZERO;
  endfunction

endpackage

// File: rtl/srt_qsel.sv
`timescale 1ns/1ps
module srt_qsel #(
  parameter int W = 8
) (
  input  logic signed [W+2:0] rem_cur,
  input  logic [W-1:0]        dvs,
  input  logic                adaptive,
  output srt_pkg::digit_e     dig,
  output logic signed [4:0]   est,
  output logic [4:0]          kq,
  output logic signed [W+2:0] rem_nxt
);
  import srt_pkg::*;

  logic signed [W+2:0] dbl;
  logic signed [W+2:0] dext;

  always_comb begin
    dbl  = rem_cur <<< 1;
    dext = $signed({3'b000, dvs});
    // only sign, integer and two fraction bits of the doubled remainder
    est  = dbl[W+2:W-2];
    kq   = quarter_const(adaptive, dvs[W-1:W-2]);
    dig  = pick_digit(est, kq);
    unique case (dig)
      DIG_PLUS:  rem_nxt = dbl - dext;
      DIG_MINUS: rem_nxt = dbl + dext;
      default:   rem_nxt = dbl;
    endcase
  end

endmodule

// File: rtl/srt_ctrl.sv
`timescale 1ns/1ps
module srt_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic fin_en,
  output logic busy
);
  import srt_pkg::*;

  localparam int CW = $clog2(W + 1);

  state_e        state;
  logic [CW-1:0] cnt;
  logic          last_step;

  assign load_en   = (state == ST_IDLE) && start;
  assign step_en   = (state == ST_RUN);
  assign fin_en    = (state == ST_FIN);
  assign busy      = (state != ST_IDLE);
  assign last_step = (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_step) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/srt_qacc.sv
`timescale 1ns/1ps
module srt_qacc #(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step,
  input  srt_pkg::digit_e          dig,
  output logic [W-1:0]             pos_bits,
  output logic [W-1:0]             neg_bits,
  output logic [$clog2(W+1)-1:0]   ops
);
  import srt_pkg::*;

  localparam int OPW = $clog2(W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_bits <= '0;
      neg_bits <= '0;
      ops      <= '0;
    end else if (clr) begin
      pos_bits <= '0;
      neg_bits <= '0;
      ops      <= '0;
    end else if (step) begin
      pos_bits <= {pos_bits[W-2:0], dig == DIG_PLUS};
      neg_bits <= {neg_bits[W-2:0], dig == DIG_MINUS};
      if (dig != DIG_ZERO) ops <= ops + OPW'(1);
    end
  end

endmodule

// File: rtl/srt_divider.sv
`timescale 1ns/1ps
module srt_divider #(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   adaptive,
  input  logic [W-1:0]           dividend,
  input  logic [W-1:0]           divisor,
  output logic [W-1:0]           quotient,
  output logic [W-1:0]           remainder,
  output logic [$clog2(W+1)-1:0] op_count,
  output logic                   done
);
  import srt_pkg::*;

  localparam int OPW = $clog2(W + 1);
  localparam int RW  = W + 3;

  // signed-digit to binary, with one-LSB correction for a negative remainder
  function automatic logic [W-1:0] to_binary(input logic [W-1:0] p, input logic [W-1:0] n,
                                             input logic fix);
    logic [W:0] diff;
    diff = {1'b0, p} - {1'b0, n} - {{W{1'b0}}, fix};
    return diff[W-1:0];
  endfunction

  function automatic logic [W-1:0] fix_rem(input logic signed [RW-1:0] r, input logic [W-1:0] d);
    logic signed [RW-1:0] s;
    s = r[RW-1] ? r + $signed({3'b000, d}) : r;
    return s[W-1:0];
  endfunction

  logic                 load_en, step_en, fin_en, busy;
  logic signed [RW-1:0] rem_q, rem_nxt;
  logic [W-1:0]         dvs_q, pos_bits, neg_bits;
  logic                 mode_q;
  logic [OPW-1:0]       ops_run;
  digit_e               dig;
  logic signed [4:0]    est;
  logic [4:0]           kq;

  srt_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load_en(load_en), .step_en(step_en), .fin_en(fin_en), .busy(busy)
  );

  srt_qsel #(.W(W)) u_qsel (
    .rem_cur(rem_q), .dvs(dvs_q), .adaptive(mode_q),
    .dig(dig), .est(est), .kq(kq), .rem_nxt(rem_nxt)
  );

  srt_qacc #(.W(W)) u_qacc (
    .clk(clk), .rst_n(rst_n), .clr(load_en), .step(step_en), .dig(dig),
    .pos_bits(pos_bits), .neg_bits(neg_bits), .ops(ops_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      mode_q <= 1'b0;
    end else if (load_en) begin
      rem_q  <= $signed({3'b000, dividend});
      dvs_q  <= divisor;
      mode_q <= adaptive;
    end else if (step_en) begin
      rem_q  <= rem_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient  <= '0;
      remainder <= '0;
      op_count  <= '0;
      done      <= 1'b0;
    end else begin
      done <= fin_en;
      if (fin_en) begin
        quotient  <= to_binary(pos_bits, neg_bits, rem_q[RW-1]);
        remainder <= fix_rem(rem_q, dvs_q);
        op_count  <= ops_run;
      end
    end
  end

endmodule

// File: rtl/srt_divider_chk.sv
`timescale 1ns/1ps
module srt_divider_chk #(
  parameter int W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   done,
  input logic                   busy,
  input logic                   step_en,
  input logic                   fin_en,
  input srt_pkg::digit_e        dig,
  input logic signed [W+2:0]    rem_q,
  input logic [W-1:0]           dvs_q,
  input logic [W-1:0]           quotient,
  input logic [W-1:0]           remainder,
  input logic [$clog2(W+1)-1:0] op_count,
  input logic [$clog2(W+1)-1:0] ops_run
);
  import srt_pkg::*;

  logic signed [W+2:0] dext;
  assign dext = $signed({3'b000, dvs_q});

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (rem_q < dext) && (rem_q >= -dext));

  p_rem_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> remainder < dvs_q);

  p_zero_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && dig == DIG_ZERO) |=> $stable(ops_run));

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_en) |=> busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_en |=> $stable(quotient) && $stable(remainder) && $stable(op_count));

endmodule

bind srt_divider srt_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
  .step_en(step_en), .fin_en(fin_en), .dig(dig), .rem_q(rem_q), .dvs_q(dvs_q),
  .quotient(quotient), .remainder(remainder), .op_count(op_count), .ops_run(ops_run)
);

// File: tb/sim_srt_divider.sv
`timescale 1ns/1ps
module sim_srt_divider;
  localparam int W   = 8;
  localparam int OPW = $clog2(W + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           adaptive = 1'b0;
  logic [W-1:0]   dividend = '0;
  logic [W-1:0]   divisor = 8'h80;
  logic [W-1:0]   quotient, remainder;
  logic [OPW-1:0] op_count;
  logic           done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  srt_divider #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .adaptive(adaptive),
    .dividend(dividend), .divisor(divisor), .quotient(quotient),
    .remainder(remainder), .op_count(op_count), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // step model: digit chosen by comparing 2r with K = kq/4, r scaled by 2^W
  function automatic longint ops_model(input longint x, input longint d, input bit adapt);
    longint kq, r, t, lim, cnt;
    kq  = adapt ? (d >> (W - 2)) : 2;
    lim = kq * (longint'(1) << W);
    r   = x;
    cnt = 0;
    for (int i = 0; i < W; i++) begin
      t = 2 * r;
      if (4 * t >= lim) begin r = t - d; cnt++; end
      else if (4 * t < -lim) begin r = t + d; cnt++; end
      else r = t;
    end
    return cnt;
  endfunction

  task automatic run_div(input logic [W-1:0] x, input logic [W-1:0] d, input bit adapt,
                         input bit intrude);
    bit early;
    early = 1'b0;
    @(negedge clk);
    dividend = x; divisor = d; adaptive = adapt; start = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= W + 1; k++) begin
      if (intrude && k == 3) begin
        start = 1'b1; dividend = ~x; divisor = 8'h80 | ~d; adaptive = ~adapt;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (k <= W && done) early = 1'b1;
    end
    chk(intrude ? "R7 done timing with intrusion" : "R2 no early done", early, 0);
    chk("R2 done on finishing cycle", done, 1);
    chk(intrude ? "R7 R3 quotient" : "R3 quotient", quotient, (longint'(x) << W) / d);
    chk(intrude ? "R7 R3 remainder" : "R3 remainder", remainder, (longint'(x) << W) % d);
    chk(adapt ? "R5 R6 op count" : "R4 R6 op count", op_count, ops_model(x, d, adapt));
    @(negedge clk);
    chk("R2 done single cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d, x;
    logic [W-1:0] hq, hr;
    logic [OPW-1:0] ho;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done, 0);
    chk("R1 quotient in reset", quotient, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 quotient after reset", quotient, 0);
    chk("R1 remainder after reset", remainder, 0);
    chk("R1 op count after reset", op_count, 0);

    // directed corners, both modes
    for (int m = 0; m < 2; m++) begin
      run_div(8'h00, 8'hC3, m[0], 1'b0);
      chk("R6 zero dividend no operations", op_count, 0);
      run_div(8'h7F, 8'h80, m[0], 1'b0);
      run_div(8'hFE, 8'hFF, m[0], 1'b0);
      run_div(8'h01, 8'hFF, m[0], 1'b0);
      run_div(8'h60, 8'hC0, m[0], 1'b0);
      run_div(8'hA0, 8'hE1, m[0], 1'b0);
    end

    // busy intrusion
    run_div(8'h55, 8'hB7, 1'b1, 1'b1);
    run_div(8'h9A, 8'hD3, 1'b0, 1'b1);

    // hold after completion
    run_div(8'h3C, 8'h9E, 1'b1, 1'b0);
    hq = quotient; hr = remainder; ho = op_count;
    for (int k = 0; k < 4; k++) begin
      dividend = W'($urandom); divisor = 8'h80 | W'($urandom); adaptive = ~adaptive;
      @(negedge clk);
    end
    chk("R8 quotient held", quotient, hq);
    chk("R8 remainder held", remainder, hr);
    chk("R8 op count held", op_count, ho);

    // constrained random
    for (int i = 0; i < 300; i++) begin
      d = 8'h80 | W'($urandom);
      x = W'($urandom % d);
      run_div(x, d, i[0], (i % 37) == 5);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule